// File: doc/BRIEF.md
# Queued SPI Master Command FIFO

This block is an SPI master that drains a queue of self-describing transmit words. Software writes 32-bit push words through a register port. The upper half of each word is a command: it chooses the chip select, the timing set that fixes the frame length and bit order, whether chip select stays asserted afterwards, whether the queue stops after this frame, and whether the frame counter restarts. The lower half is the data to send.

Frames leave one after another while the master enable is set and no end-of-queue halt is pending. Each received frame is cut to its frame size and placed in a receive FIFO, which software empties by reading the pop register. Sticky completion flags can drive an interrupt output through per-flag enables. The serial clock is produced by a fixed-divider clock engine, with mode 0 timing: data changes on the falling edge and is sampled on the rising edge.

Register word addresses: 0 control, 1 frame count, 2 status, 3 interrupt enable, 4 push (write), 5 pop (read), 8 to 15 timing sets 0 to 7. A read returns its value in the cycle after the read strobe.

Top module: `spiq_master_top`

## Requirements
- R1: After reset, control reads 0x003F0000, status reads 0x02000000, the count register reads 0, every chip-select output is 1, and irq is 0.
- R2: A push word (command in bits 31:16, data in bits 15:0) enters a TX FIFO of TX_DEPTH entries, and frames are sent in push order. A push into a full TX FIFO is dropped. The timing set chosen by command bits 14:12 gives the frame length as bits 3:0 plus one. Bits go out MSB first unless bit 4 of that timing set is 1, in which case they go out LSB first.
- R3: During a frame, each chip select enabled by the one-hot command bits 5:0 drives the inverse of its idle level from control bits 21:16. When command bit 15 is set, chip select stays active after the frame, even while the TX FIFO is empty. Without bit 15 it returns to idle.
- R4: Count register bits 31:16 increase by one for each completed frame. A frame whose command bit 10 is set first clears the count to zero, so the count reads 1 once that frame completes.
- R5: A frame whose command bit 11 is set raises status bit 28 when it completes. No further frame starts until that bit is cleared.
- R6: Each received frame, masked to its frame length, enters an RX FIFO of RX_DEPTH entries. Reading the pop register removes the oldest entry and returns it in bits 15:0. A pop of an empty RX FIFO returns 0. A frame that completes while the RX FIFO is full is dropped and sets status bit 19.
- R7: Every completed frame sets status bit 31. Writing 1 clears bits 31, 28 and 19, and writing 0 leaves them unchanged. Status bit 25 reads 1 while the TX FIFO is not full, and bit 17 reads 1 while the RX FIFO is not empty.
- R8: irq is high exactly when (status bit 31 and enable bit 31) or (status bit 28 and enable bit 28).
- R9: Writing 1 to control bit 11 empties the TX FIFO, and writing 1 to control bit 10 empties the RX FIFO. No frame starts while control bit 31 (master enable) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rdEn |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | 6 | Chip-select outputs |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with TX_DEPTH = 4, RX_DEPTH = 4 and HALF_CYCLES = 2. With that divider a 16-bit frame lasts about 66 cycles, which leaves room for the halt, flush and master-enable windows to be observed at the register port. A depth of four means a burst of five words reaches both the dropped-push case on the TX side and the overflow case on the RX side. The serial output is looped back to the input, so the expected receive words follow from the pushed data and the frame lengths. The bench also captures the bits as they appear on the serial output to confirm the bit order.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int DATA_W = 16;
  localparam int NUM_TSETS = 8;
  localparam int CS_W = 6;

  localparam logic [3:0] ADDR_CTRL  = 4'd0;
  localparam logic [3:0] ADDR_COUNT = 4'd1;
  localparam logic [3:0] ADDR_STAT  = 4'd2;
  localparam logic [3:0] ADDR_IRQEN = 4'd3;
  localparam logic [3:0] ADDR_PUSH  = 4'd4;
  localparam logic [3:0] ADDR_POP   = 4'd5;

  localparam int BIT_MASTER   = 31;
  localparam int BIT_FLUSHTX  = 11;
  localparam int BIT_FLUSHRX  = 10;
  localparam int BIT_TCF      = 31;
  localparam int BIT_EOQ      = 28;
  localparam int BIT_TXFILL   = 25;
  localparam int BIT_RXOVF    = 19;
  localparam int BIT_RXDRAIN  = 17;

  typedef struct packed {
    logic             cont;
    logic [2:0]       tsel;
    logic             eoq;
    logic             ctcnt;
    logic [3:0]       spare;
    logic [CS_W-1:0]  pcs;
  } spiq_cmd_t;

  typedef struct packed {
    logic loadFrame;
    logic sampleBit;
    logic shiftBit;
    logic frameDone;
  } spiq_strobe_t;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  assert_fifo_push_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(push && full));
  assert_fifo_pop_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(pop && empty));
endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      masterEn,
  input  logic                      txEmpty,
  input  logic                      halted,
  input  logic [$clog2(DATA_W)-1:0] lastIdx,
  output spiq_strobe_t              stb,
  output logic                      sck,
  output logic                      busy
);
  localparam int DIV_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int IDX_W = $clog2(DATA_W);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} state_t;
  state_t state;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic halfDone;

  assign halfDone = (divCnt == DIV_W'(HALF_CYCLES - 1));
  assign sck  = (state == ST_HIGH);
  assign busy = (state != ST_IDLE);

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE: stb.loadFrame = masterEn && !txEmpty && !halted;
      ST_LOW:  stb.sampleBit = halfDone;
      ST_HIGH: begin
        stb.frameDone = halfDone && (bitIdx == lastIdx);
        stb.shiftBit  = halfDone && (bitIdx != lastIdx);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
    end else begin
      divCnt <= halfDone ? '0 : divCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          divCnt <= '0;
          bitIdx <= '0;
          if (stb.loadFrame) state <= ST_LOW;
        end
        ST_LOW: if (halfDone) state <= ST_HIGH;
        ST_HIGH: if (halfDone) begin
          if (stb.frameDone) state <= ST_IDLE;
          else begin
            state  <= ST_LOW;
            bitIdx <= bitIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spiq_datapath.sv
module spiq_datapath
  import spiq_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [3:0]                addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  input  spiq_strobe_t              stb,
  input  logic                      busy,
  output logic                      masterEn,
  output logic                      txEmpty,
  output logic                      halted,
  output logic [$clog2(DATA_W)-1:0] lastIdx,
  input  logic                      miso,
  output logic                      mosi,
  output logic [CS_W-1:0]           csOut,
  output logic                      irq
);
  localparam int IDX_W = $clog2(DATA_W);

  logic masterReg;
  logic [CS_W-1:0] idleLvl;
  logic irqEnTcf, irqEnEoq;
  logic [IDX_W-1:0] tsetSize [NUM_TSETS];
  logic tsetLsb [NUM_TSETS];
  logic tcfFlag, eoqFlag, ovfFlag;
  logic [15:0] xferCnt;
  spiq_cmd_t cmd, headCmd;
  logic csActive;
  logic [DATA_W-1:0] txShift, rxShift, rxWord, rxHead, loadMask, curMask;
  logic [31:0] txHead;
  logic txFull, rxFull, rxEmpty;
  logic wrCtrl, wrStat, wrPush, rdPop;
  logic curLsb;
  logic [IDX_W-1:0] curSize, loadSize;

  function automatic logic [DATA_W-1:0] maskOf(input logic [IDX_W-1:0] size);
    logic [DATA_W:0] wide;
    wide = ({{DATA_W{1'b0}}, 1'b1} << size) << 1;
    return DATA_W'(wide - 1'b1);
  endfunction

  assign wrCtrl = wrEn && (addr == ADDR_CTRL);
  assign wrStat = wrEn && (addr == ADDR_STAT);
  assign wrPush = wrEn && (addr == ADDR_PUSH);
  assign rdPop  = rdEn && (addr == ADDR_POP);

  assign headCmd  = spiq_cmd_t'(txHead[31:16]);
  assign loadSize = tsetSize[headCmd.tsel];
  assign loadMask = maskOf(loadSize);
  assign curSize  = tsetSize[cmd.tsel];
  assign curLsb   = tsetLsb[cmd.tsel];
  assign curMask  = maskOf(curSize);
  assign lastIdx  = curSize;
  assign masterEn = masterReg;
  assign halted   = eoqFlag;

  spiq_fifo #(.WIDTH(32), .DEPTH(TX_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(wrCtrl && wdata[BIT_FLUSHTX]),
    .push(wrPush && !txFull), .din(wdata), .pop(stb.loadFrame),
    .head(txHead), .full(txFull), .empty(txEmpty));

  assign rxWord = (curLsb ? (rxShift >> (IDX_W'(DATA_W - 1) - curSize)) : rxShift) & curMask;

  spiq_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(wrCtrl && wdata[BIT_FLUSHRX]),
    .push(stb.frameDone && !rxFull), .din(rxWord), .pop(rdPop && !rxEmpty),
    .head(rxHead), .full(rxFull), .empty(rxEmpty));

  assign mosi  = curLsb ? txShift[0] : txShift[curSize];
  assign csOut = idleLvl ^ ({CS_W{csActive}} & cmd.pcs);
  assign irq   = (tcfFlag && irqEnTcf) || (eoqFlag && irqEnEoq);

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterReg <= 1'b0;
      idleLvl   <= '1;
      irqEnTcf  <= 1'b0;
      irqEnEoq  <= 1'b0;
      for (int i = 0; i < NUM_TSETS; i++) begin
        tsetSize[i] <= IDX_W'(DATA_W - 1);
        tsetLsb[i]  <= 1'b0;
      end
    end else if (wrEn) begin
      if (addr == ADDR_CTRL) begin
        masterReg <= wdata[BIT_MASTER];
        idleLvl   <= wdata[16 +: CS_W];
      end
      if (addr == ADDR_IRQEN) begin
        irqEnTcf <= wdata[BIT_TCF];
        irqEnEoq <= wdata[BIT_EOQ];
      end
      if (addr[3]) begin
        tsetSize[addr[2:0]] <= wdata[IDX_W-1:0];
        tsetLsb[addr[2:0]]  <= wdata[IDX_W];
      end
    end
  end

  // Frame state, shifters, counter, sticky flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd      <= '0;
      csActive <= 1'b0;
      txShift  <= '0;
      rxShift  <= '0;
      xferCnt  <= '0;
      tcfFlag  <= 1'b0;
      eoqFlag  <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (stb.loadFrame) begin
        cmd      <= headCmd;
        csActive <= 1'b1;
        txShift  <= txHead[DATA_W-1:0] & loadMask;
        rxShift  <= '0;
        if (headCmd.ctcnt) xferCnt <= '0;
      end
      if (stb.sampleBit)
        rxShift <= curLsb ? {miso, rxShift[DATA_W-1:1]} : {rxShift[DATA_W-2:0], miso};
      if (stb.shiftBit)
        txShift <= curLsb ? (txShift >> 1) : (txShift << 1);

      if (stb.frameDone)                     tcfFlag <= 1'b1;
      else if (wrStat && wdata[BIT_TCF])     tcfFlag <= 1'b0;
      if (stb.frameDone && cmd.eoq)          eoqFlag <= 1'b1;
      else if (wrStat && wdata[BIT_EOQ])     eoqFlag <= 1'b0;
      if (stb.frameDone && rxFull)           ovfFlag <= 1'b1;
      else if (wrStat && wdata[BIT_RXOVF])   ovfFlag <= 1'b0;

      if (stb.frameDone) begin
        xferCnt  <= xferCnt + 1'b1;
        csActive <= cmd.cont;
      end
    end
  end

  // Registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else if (rdEn) begin
      rdata <= '0;
      if (addr[3]) rdata <= {{(31-IDX_W){1'b0}}, tsetLsb[addr[2:0]], tsetSize[addr[2:0]]};
      else begin
        unique case (addr)
          ADDR_CTRL:  rdata <= {masterReg, 9'b0, idleLvl, 16'b0};
          ADDR_COUNT: rdata <= {xferCnt, 16'b0};
          ADDR_STAT: begin
            rdata[BIT_TCF]     <= tcfFlag;
            rdata[BIT_EOQ]     <= eoqFlag;
            rdata[BIT_TXFILL]  <= !txFull;
            rdata[BIT_RXOVF]   <= ovfFlag;
            rdata[BIT_RXDRAIN] <= !rxEmpty;
          end
          ADDR_IRQEN: begin
            rdata[BIT_TCF] <= irqEnTcf;
            rdata[BIT_EOQ] <= irqEnEoq;
          end
          ADDR_POP: rdata <= {16'b0, rxEmpty ? 16'b0 : rxHead};
          default: ;
        endcase
      end
    end
  end

  assert_start_needs_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadFrame |-> !txEmpty);
  assert_eoq_halts_R5: assert property (@(posedge clk) disable iff (!rstN)
    eoqFlag |-> !stb.loadFrame);
  assert_cs_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> csActive);
  assert_master_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !masterReg |-> !stb.loadFrame);
endmodule

// File: rtl/spiq_master_top.sv
module spiq_master_top
  import spiq_pkg::*;
#(
  parameter int TX_DEPTH    = 4,
  parameter int RX_DEPTH    = 4,
  parameter int HALF_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [5:0]  csOut,
  output logic        irq
);
  spiq_strobe_t stb;
  logic busy, masterEn, txEmpty, halted;
  logic [$clog2(DATA_W)-1:0] lastIdx;

  spiq_ctrl #(.HALF_CYCLES(HALF_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .txEmpty(txEmpty),
    .halted(halted), .lastIdx(lastIdx), .stb(stb), .sck(sck), .busy(busy));

  spiq_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .stb(stb), .busy(busy),
    .masterEn(masterEn), .txEmpty(txEmpty), .halted(halted),
    .lastIdx(lastIdx), .miso(miso), .mosi(mosi), .csOut(csOut), .irq(irq));
endmodule

// File: tb/sim_spiq_master_top.sv
module sim_spiq_master_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sck, mosi, miso;
  logic [5:0] csOut;
  logic irq;
  logic [15:0] serialCap = '0;

  int nChecks = 0;
  int nFail = 0;
  int expCnt = 0;
  logic [15:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso = mosi;
  always @(posedge sck) serialCap <= {serialCap[14:0], mosi};

  spiq_master_top #(.TX_DEPTH(4), .RX_DEPTH(4), .HALF_CYCLES(2)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .csOut(csOut), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdata;
  endtask

  function automatic logic [15:0] mkCmd(input bit cont, input logic [2:0] tsel,
      input bit eoq, input bit ctcnt, input logic [5:0] pcs);
    return {cont, tsel, eoq, ctcnt, 4'b0, pcs};
  endfunction

  // Driver: push a frame and record what the loopback must return
  task automatic pushFrame(input logic [15:0] c, input logic [15:0] d,
      input logic [15:0] mask, input bit expectRx);
    regWrite(4'd4, {c, d});
    if (expectRx) expQ.push_back(d & mask);
  endtask

  // Monitor side of the scoreboard: pop and compare in order
  task automatic popCheck(input string req);
    logic [31:0] v;
    logic [15:0] e;
    regRead(4'd5, v);
    e = (expQ.size() > 0) ? expQ.pop_front() : 16'h0;
    check(req, v, {16'h0, e});
  endtask

  task automatic waitCount(input int target);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      regRead(4'd1, v);
      if (v[31:16] == target[15:0]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(4'd0, v); check("R1 ctrl", v, 32'h003F0000);
    regRead(4'd2, v); check("R1 status", v, 32'h02000000);
    regRead(4'd1, v); check("R1 count", v, 32'h0);
    check("R1 cs idle", {26'h0, csOut}, 32'h3F);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // timing sets: 0 = 16-bit MSB, 1 = 8-bit LSB, 2 = 8-bit MSB
    regWrite(4'd8, 32'h0F);
    regWrite(4'd9, 32'h17);
    regWrite(4'd10, 32'h07);
    regWrite(4'd0, 32'h803F0000);

    // R2/R4/R6 basic stream
    pushFrame(mkCmd(0, 0, 0, 1, 6'h01), 16'hA1B2, 16'hFFFF, 1);
    pushFrame(mkCmd(0, 0, 0, 0, 6'h01), 16'hC3D4, 16'hFFFF, 1);
    pushFrame(mkCmd(0, 0, 0, 0, 6'h01), 16'h0F0F, 16'hFFFF, 1);
    expCnt = 3; waitCount(expCnt);
    regRead(4'd1, v); check("R4 count after three", v, 32'h00030000);
    regRead(4'd2, v); check("R7 tcf and rx drain set", v & 32'h80020000, 32'h80020000);
    popCheck("R2 order word0");
    popCheck("R2 order word1");
    popCheck("R6 word2");
    regRead(4'd5, v); check("R6 pop empty", v, 32'h0);
    check("R3 cs idle after frame", {26'h0, csOut}, 32'h3F);
    regWrite(4'd2, 32'h0);
    regRead(4'd2, v); check("R7 write 0 keeps tcf", v[31], 1'b1);
    regWrite(4'd2, 32'h80000000);
    regRead(4'd2, v); check("R7 w1c tcf", v, 32'h02000000);

    // R3 continuation holds chip select with empty queue
    pushFrame(mkCmd(1, 0, 0, 0, 6'h04), 16'h5555, 16'hFFFF, 1);
    expCnt++; waitCount(expCnt);
    repeat (40) @(negedge clk);
    check("R3 cs held while empty", {26'h0, csOut}, 32'h3B);
    pushFrame(mkCmd(0, 0, 0, 0, 6'h04), 16'h1234, 16'hFFFF, 1);
    expCnt++; waitCount(expCnt);
    check("R3 cs released", {26'h0, csOut}, 32'h3F);
    popCheck("R6 cont word0");
    popCheck("R6 cont word1");
    regWrite(4'd0, 32'h800F0000);
    @(negedge clk);
    check("R3 idle levels", {26'h0, csOut}, 32'h0F);
    regWrite(4'd0, 32'h803F0000);

    // R2 bit order and R6 masking, R4 counter clear mid stream
    pushFrame(mkCmd(0, 1, 0, 1, 6'h01), 16'h12AB, 16'h00FF, 1);
    expCnt = 1; waitCount(expCnt);
    regRead(4'd1, v); check("R4 ctcnt restart", v, 32'h00010000);
    check("R2 lsb first serial", {24'h0, serialCap[7:0]}, 32'hD5);
    popCheck("R6 lsb masked");
    pushFrame(mkCmd(0, 2, 0, 0, 6'h01), 16'h12AB, 16'h00FF, 1);
    expCnt++; waitCount(expCnt);
    check("R2 msb first serial", {24'h0, serialCap[7:0]}, 32'hAB);
    popCheck("R6 msb masked");

    // R5 end of queue halt, R8 irq
    regWrite(4'd3, 32'h10000000);
    pushFrame(mkCmd(0, 0, 1, 0, 6'h01), 16'h3C3C, 16'hFFFF, 1);
    pushFrame(mkCmd(0, 0, 0, 0, 6'h01), 16'h6969, 16'hFFFF, 1);
    expCnt++; waitCount(expCnt);
    repeat (200) @(negedge clk);
    regRead(4'd1, v); check("R5 halted count", v[31:16], expCnt);
    regRead(4'd2, v); check("R5 eoq flag", v[28], 1'b1);
    check("R8 irq on eoq", {31'h0, irq}, 32'h1);
    regWrite(4'd2, 32'h10000000);
    expCnt++; waitCount(expCnt);
    regRead(4'd1, v); check("R5 resumes after clear", v[31:16], expCnt);
    check("R8 irq off", {31'h0, irq}, 32'h0);
    regWrite(4'd3, 32'h80000000);
    @(negedge clk);
    check("R8 irq on tcf", {31'h0, irq}, 32'h1);
    regWrite(4'd3, 32'h0);
    popCheck("R6 eoq word0");
    popCheck("R6 eoq word1");

    // R6 RX overflow
    regWrite(4'd2, 32'h80080000);
    for (int i = 0; i < 4; i++)
      pushFrame(mkCmd(0, 0, 0, 0, 6'h02), 16'h1000 + 16'(i), 16'hFFFF, 1);
    expCnt += 4; waitCount(expCnt);
    pushFrame(mkCmd(0, 0, 0, 0, 6'h02), 16'hDEAD, 16'hFFFF, 0);
    expCnt++; waitCount(expCnt);
    regRead(4'd2, v); check("R6 overflow flag", v[19], 1'b1);
    for (int i = 0; i < 4; i++) popCheck("R6 overflow keeps oldest");
    regWrite(4'd2, 32'h00080000);
    regRead(4'd2, v); check("R7 w1c overflow", v[19], 1'b0);

    // R2 TX full drop, R9 master gate
    regWrite(4'd0, 32'h003F0000);
    for (int i = 0; i < 5; i++)
      pushFrame(mkCmd(0, 0, 0, 0, 6'h01), 16'h2000 + 16'(i), 16'hFFFF, i < 4);
    repeat (100) @(negedge clk);
    regRead(4'd1, v); check("R9 no start without master", v[31:16], expCnt);
    regRead(4'd2, v); check("R7 tx fill clear when full", v[25], 1'b0);
    regWrite(4'd0, 32'h803F0000);
    expCnt += 4; waitCount(expCnt);
    repeat (200) @(negedge clk);
    regRead(4'd1, v); check("R2 fifth push dropped", v[31:16], expCnt);
    for (int i = 0; i < 4; i++) popCheck("R2 full burst");
    regRead(4'd2, v); check("R7 rx drain clear", v[17], 1'b0);

    // R9 flushes
    regWrite(4'd0, 32'h003F0000);
    pushFrame(mkCmd(0, 0, 0, 0, 6'h01), 16'h7777, 16'hFFFF, 0);
    pushFrame(mkCmd(0, 0, 0, 0, 6'h01), 16'h8888, 16'hFFFF, 0);
    regWrite(4'd0, 32'h003F0800);
    regWrite(4'd0, 32'h803F0000);
    repeat (300) @(negedge clk);
    regRead(4'd1, v); check("R9 tx flush", v[31:16], expCnt);
    pushFrame(mkCmd(0, 0, 0, 0, 6'h01), 16'h9999, 16'hFFFF, 0);
    expCnt++; waitCount(expCnt);
    regWrite(4'd0, 32'h803F0400);
    regRead(4'd2, v); check("R9 rx flush", v[17], 1'b0);
    regRead(4'd5, v); check("R9 rx flush pop", v, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule